// File: doc/BRIEF.md
# Wakeup Start-Up Delay Sequencer

This block controls the way a processor core leaves its low-power halt or idle state. When the core issues a halt command, the sequencer stops both the oscillator and the clock that feeds the rest of the chip. A later wakeup request turns on only the oscillator and an internal start-up counter. The counter is clocked by an instruction-rate tick, which is the oscillator clock divided by 10. It is loaded with 256 and counts down. The gated system clock comes back only when the counter expires, so the oscillator always has a fixed 2560-cycle settling window before any logic downstream runs again.

The block also tells the core how to resume. When the start-up phase begins, it captures the interrupt-enable qualifier. A captured 1 means the core takes the pending interrupt service routine first. A captured 0 means the core continues at the instruction after the one that halted it. The mode is handed over through a valid/ready style pair, `resume_valid` and `resume_ack`. The valid is raised on the same edge the clock gate reopens. The valid and the mode then hold steady for as long as the core withholds its acknowledge, and that acknowledge is the only back-pressure. A new halt is refused while a mode is still waiting to be acknowledged.

The block's own clock is the oscillator clock. The analog oscillator itself and its amplitude qualification are outside this block.

Top module: `wake_seq`

## Requirements
- R1: After reset the block is running: `osc_en`=1, `clk_gate_en`=1, `resume_valid`=0, `resume_isr`=0.
- R2: If `halt_cmd` is sampled high while running with `resume_valid`=0, then from the next cycle `osc_en`=0 and `clk_gate_en`=0 (halted).
- R3: If `wake_req` is sampled high while halted, then from the next cycle `osc_en`=1 and `clk_gate_en`=0 (start-up).
- R4: Start-up lasts exactly DIV*LOAD = 2560 clock cycles: `clk_gate_en` is 0 for the 2560 cycles that follow the start-up entry edge, and is 1 on the next cycle.
- R5: During start-up, `wake_req` and `halt_cmd` have no effect; the start-up length is unchanged.
- R6: `resume_isr` takes the value of `irq_en` sampled on the start-up entry edge: 1 = run the interrupt service routine first, 0 = resume at the next instruction.
- R7: `resume_valid` rises on the same edge as `clk_gate_en`; while `resume_valid`=1 and `resume_ack`=0, `resume_valid` and `resume_isr` hold; `resume_valid` is 0 on the cycle after `resume_ack` is sampled high with `resume_valid`=1.
- R8: While running, `wake_req` has no effect, and `halt_cmd` is ignored while `resume_valid`=1.
- R9: Changes of `irq_en` after the start-up entry edge do not alter `resume_isr`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| halt_cmd | input | 1 | Request from the core to enter halt/idle |
| wake_req | input | 1 | Wakeup request |
| irq_en | input | 1 | Interrupt-enable qualifier for the wakeup |
| resume_ack | input | 1 | Core accepts the resume mode (ready) |
| osc_en | output | 1 | Oscillator enable |
| clk_gate_en | output | 1 | Enable for the system clock gate |
| resume_valid | output | 1 | Resume mode available |
| resume_isr | output | 1 | 1 = take interrupt first, 0 = next instruction |

## Verification
A wrong internal state shows up at the two enables on the very next cycle. A halted or start-up state shows its own pattern of `osc_en` and `clk_gate_en`, and the pair `osc_en`=0 with `clk_gate_en`=1 must never appear. A fault in the prescaler or the counter cannot be seen during the start-up phase itself. It shows only when the gate reopens, because the reopening then comes a number of cycles early or late, so the bench counts every start-up cycle exactly. A mode that is captured on the wrong edge or lost later shows up as a `resume_isr` that differs from the qualifier as it stood at wakeup, or as `resume_valid` dropping without an acknowledge.

// File: rtl/wake_seq_pkg.sv
package wake_seq_pkg;
  typedef enum logic [1:0] {
    ST_RUN     = 2'd0,
    ST_HALTED  = 2'd1,
    ST_STARTUP = 2'd2
  } wake_state_t;
endpackage

// File: rtl/wake_prescaler.sv
module wake_prescaler #(
  parameter int DIV = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] phase;

  assign tick = run && (phase == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         phase <= '0;
    else if (clear)     phase <= '0;
    else if (run) begin
      if (phase == LAST) phase <= '0;
      else               phase <= phase + 1'b1;
    end
  end
endmodule

// File: rtl/wake_startup_timer.sv
module wake_startup_timer #(
  parameter int LOAD = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic tick,
  output logic expire
);
  localparam int CW = $clog2(LOAD + 1);
  localparam logic [CW-1:0] INIT = CW'(LOAD);
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic [CW-1:0] remain;

  assign expire = tick && (remain == ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      remain <= '0;
    else if (load)                   remain <= INIT;
    else if (tick && remain != '0)   remain <= remain - 1'b1;
  end
endmodule

// File: rtl/wake_seq_fsm.sv
module wake_seq_fsm
  import wake_seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic halt_cmd,
  input  logic wake_req,
  input  logic irq_en,
  input  logic resume_ack,
  input  logic expire,
  output logic enter_startup,
  output logic in_startup,
  output logic osc_en,
  output logic clk_gate_en,
  output logic resume_valid,
  output logic resume_isr
);
  wake_state_t state, state_nx;
  logic accept_halt;

  assign accept_halt   = (state == ST_RUN) && halt_cmd && !resume_valid;
  assign enter_startup = (state == ST_HALTED) && wake_req;
  assign in_startup    = (state == ST_STARTUP);

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_RUN:     if (accept_halt)   state_nx = ST_HALTED;
      ST_HALTED:  if (enter_startup) state_nx = ST_STARTUP;
      ST_STARTUP: if (expire)        state_nx = ST_RUN;
      default:                       state_nx = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_RUN;
    else        state <= state_nx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resume_valid <= 1'b0;
      resume_isr   <= 1'b0;
    end else begin
      if (enter_startup) resume_isr <= irq_en;
      if (in_startup && expire)             resume_valid <= 1'b1;
      else if (resume_valid && resume_ack)  resume_valid <= 1'b0;
    end
  end

  assign osc_en      = (state != ST_HALTED);
  assign clk_gate_en = (state == ST_RUN);
endmodule

// File: rtl/wake_seq.sv
module wake_seq #(
  parameter int DIV  = 10,
  parameter int LOAD = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic halt_cmd,
  input  logic wake_req,
  input  logic irq_en,
  input  logic resume_ack,
  output logic osc_en,
  output logic clk_gate_en,
  output logic resume_valid,
  output logic resume_isr
);
  logic enter_startup, in_startup, tick, expire;

  wake_seq_fsm u_fsm (
    .clk, .rst_n, .halt_cmd, .wake_req, .irq_en, .resume_ack,
    .expire, .enter_startup, .in_startup,
    .osc_en, .clk_gate_en, .resume_valid, .resume_isr
  );

  wake_prescaler #(.DIV(DIV)) u_presc (
    .clk, .rst_n, .clear(enter_startup), .run(in_startup), .tick
  );

  wake_startup_timer #(.LOAD(LOAD)) u_timer (
    .clk, .rst_n, .load(enter_startup), .tick, .expire
  );
endmodule

// File: rtl/wake_seq_chk.sv
module wake_seq_chk #(
  parameter int DIV  = 10,
  parameter int LOAD = 256
) (
  input logic clk,
  input logic rst_n,
  input logic halt_cmd,
  input logic wake_req,
  input logic irq_en,
  input logic resume_ack,
  input logic osc_en,
  input logic clk_gate_en,
  input logic resume_valid,
  input logic resume_isr
);
  localparam int TOTAL = DIV * LOAD;
  localparam int SW = $clog2(TOTAL + 2);

  logic [SW-1:0] su_cycles;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     su_cycles <= '0;
    else if (osc_en && !clk_gate_en) su_cycles <= su_cycles + 1'b1;
    else                             su_cycles <= '0;
  end

  p_gate_needs_osc_r1: assert property (@(posedge clk) disable iff (!rst_n)
    clk_gate_en |-> osc_en);

  p_halt_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_gate_en && halt_cmd && !resume_valid) |=> (!osc_en && !clk_gate_en));

  p_wake_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!osc_en && wake_req) |=> (osc_en && !clk_gate_en));

  p_delay_exact_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_gate_en) |-> (su_cycles == SW'(TOTAL)));

  p_no_overrun_r5: assert property (@(posedge clk) disable iff (!rst_n)
    su_cycles <= SW'(TOTAL));

  p_mode_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!osc_en && wake_req) |=> (resume_isr == $past(irq_en)));

  p_valid_with_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(resume_valid) |-> $rose(clk_gate_en));

  p_hold_until_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (resume_valid && !resume_ack) |=> (resume_valid && $stable(resume_isr)));

  p_halt_refused_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_gate_en && resume_valid) |=> clk_gate_en);
endmodule

bind wake_seq wake_seq_chk #(.DIV(DIV), .LOAD(LOAD)) u_chk (
  .clk, .rst_n, .halt_cmd, .wake_req, .irq_en, .resume_ack,
  .osc_en, .clk_gate_en, .resume_valid, .resume_isr
);

// File: tb/wake_seq_test.sv
`timescale 1ns/1ps
module wake_seq_test;
  localparam int DIV = 10;
  localparam int LOAD = 256;
  localparam int TOTAL = DIV * LOAD;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic halt_cmd = 1'b0, wake_req = 1'b0, irq_en = 1'b0, resume_ack = 1'b0;
  logic osc_en, clk_gate_en, resume_valid, resume_isr;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  wake_seq #(.DIV(DIV), .LOAD(LOAD)) uut (
    .clk, .rst_n, .halt_cmd, .wake_req, .irq_en, .resume_ack,
    .osc_en, .clk_gate_en, .resume_valid, .resume_isr
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  // enables packed as {osc_en, clk_gate_en}
  function automatic int en2();
    return {30'd0, osc_en, clk_gate_en};
  endfunction

  task automatic do_halt();
    @(negedge clk); halt_cmd = 1'b1;
    tick();
    @(negedge clk); halt_cmd = 1'b0;
    check(en2() == 0, "R2 halt", en2(), 0);
  endtask

  // wake from halt, then count start-up cycles with optional disturbance
  task automatic wake_and_count(input bit ie, input bit disturb, input string tag);
    int gated;
    bit early;
    gated = 0; early = 1'b0;
    @(negedge clk); wake_req = 1'b1; irq_en = ie;
    tick();
    check(en2() == 2, "R3 start-up entry", en2(), 2);
    @(negedge clk); wake_req = disturb; halt_cmd = disturb;
    if (disturb) irq_en = ~ie;
    for (int i = 0; i < TOTAL; i++) begin
      if (clk_gate_en) early = 1'b1; else gated++;
      if (disturb && i == 1000) begin
        @(negedge clk); wake_req = 1'b0; halt_cmd = 1'b0;
      end
      tick();
    end
    wake_req = 1'b0; halt_cmd = 1'b0;
    check(!early && gated == TOTAL, tag, gated, TOTAL);
    check(clk_gate_en && osc_en, "R4 gate reopens", en2(), 3);
    check(resume_valid, "R7 valid with gate", resume_valid, 1);
    check(resume_isr == ie, disturb ? "R9 mode kept" : "R6 mode", resume_isr, ie);
  endtask

  task automatic test_reset();
    check(osc_en == 1, "R1 osc_en", osc_en, 1);
    check(clk_gate_en == 1, "R1 gate", clk_gate_en, 1);
    check(resume_valid == 0, "R1 valid", resume_valid, 0);
    check(resume_isr == 0, "R1 isr", resume_isr, 0);
  endtask

  task automatic test_wake_in_run_r8();
    @(negedge clk); wake_req = 1'b1;
    tick(); tick();
    @(negedge clk); wake_req = 1'b0;
    check(en2() == 3, "R8 wake ignored in run", en2(), 3);
  endtask

  task automatic test_ack_r7(input bit exp_isr);
    for (int i = 0; i < 5; i++) tick();
    check(resume_valid && resume_isr == exp_isr, "R7 held without ack", resume_valid, 1);
    // halt refused while pending
    @(negedge clk); halt_cmd = 1'b1;
    tick(); tick();
    @(negedge clk); halt_cmd = 1'b0;
    check(en2() == 3, "R8 halt refused while pending", en2(), 3);
    @(negedge clk); resume_ack = 1'b1;
    tick();
    @(negedge clk); resume_ack = 1'b0;
    check(resume_valid == 0, "R7 cleared by ack", resume_valid, 0);
  endtask

  initial begin
    #1;
    check(1'b1, "R1 start", 0, 0);
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    test_reset();
    test_wake_in_run_r8();
    do_halt();
    wake_and_count(1'b0, 1'b0, "R4 delay");
    test_ack_r7(1'b0);
    do_halt();
    wake_and_count(1'b1, 1'b1, "R5 delay with disturbance");
    test_ack_r7(1'b1);
    done = 1'b1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (50000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule